// File: doc/BRIEF.md
# Protected Runtime Clock Prescaler

This block divides a master clock by a power of two and presents the result as a one-cycle enable pulse. Downstream synchronous logic qualifies its flops with that pulse, so it runs at the master rate divided by the selected factor. Software can change the factor while the system runs. A two-step unlock guards the change, so a stray store cannot slow the system or speed it up.

The control word has an unlock flag in bit 7 and a 4-bit divider code in bits 3:0. The first write sets the flag with the code bits zero. This opens a window four master cycles long. A second write with the flag clear stores the code, and the window closes at once. A strap input, sampled while reset is held, sets the starting factor to 1 or 8. A code change takes effect only where the current divided period ends, so the enable stream never has a shortened period.

Top module: `clk_prescale_guard`

## Requirements
- R1: While reset is held and after it is released, the stored code is 0 (divide by 1) when `strap_div8` is low and 3 (divide by 8) when it is high. The unlock flag is clear. `rd_data` reads `{unlock, 3'b000, code[3:0]}`. With the strap high, the first enable pulse comes in the 8th cycle after reset is released.
- R2: An accepted write (`wr_en` and `wr_sel` both high) with bit 7 set and bits 3:0 zero sets the unlock flag. The flag reads 1 for exactly four cycles and then clears by itself.
- R3: An accepted write with bit 7 clear while the flag is clear changes neither the stored code nor the division.
- R4: An accepted write with bit 7 clear while the flag is set stores bits 3:0 as the code and clears the flag on the same edge. The fourth edge after the unlock write is still inside the window. The fifth edge is not.
- R5: Writing the unlock word again while the window is open neither clears the flag nor extends the window.
- R6: A write with bit 7 set and a nonzero code is rejected. The flag, the code and the division stay as they were.
- R7: Codes 0 to 8 divide by 2^code. `clk_en` is high for one master cycle in every 2^code cycles.
- R8: Codes 9 to 15 are stored and read back, but the divider keeps the factor it already has.
- R9: After a code is stored, the old factor finishes its current period. From the end of that period on, pulses come every 2^new cycles.
- R10: A write with `wr_sel` low has no effect on the flag, the window or the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_div8 | input | 1 | Selects a reset factor of 8 instead of 1 |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Prescaler register selected |
| wr_data | input | 8 | Write word: bit 7 unlock, bits 3:0 code |
| rd_data | output | 8 | Readback: flag, zeros, stored code |
| clk_en | output | 1 | Divided clock enable, one master cycle wide |

## Verification
A write takes effect on the edge that samples it, so the flag and the code are visible on `rd_data` half a cycle later. The bench drives inputs on falling edges and reads at the following falling edge. It counts edges exactly to the fourth and fifth cycles of the window. A new factor appears only after the pulse that ends the old period. The bench therefore finds that pulse first, measures the two intervals that follow it, and expects 2^code cycles for each of them.

// File: rtl/clk_prescale_guard.sv
module clk_prescale_guard #(
  parameter int SEL_W      = 4,
  parameter int CNT_W      = 8,
  parameter int WIN_LEN    = 4,
  parameter int STRAP_CODE = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_div8,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       clk_en
);
  localparam int MAX_CODE = CNT_W;
  localparam int WIN_W    = $clog2(WIN_LEN + 1);

  logic             unlock_q;
  logic [WIN_W-1:0] win_q;
  logic [SEL_W-1:0] sel_q, pend_q, act_q;
  logic [CNT_W-1:0] cnt_q, mask;
  logic [SEL_W-1:0] boot_code;

  wire acc      = wr_en & wr_sel;
  wire open_req = acc & wr_data[7] & (wr_data[SEL_W-1:0] == '0);
  wire take     = acc & ~wr_data[7] & unlock_q;
  wire code_ok  = wr_data[SEL_W-1:0] <= SEL_W'(MAX_CODE);
  wire unused_bits = ^wr_data[6:SEL_W];

  assign boot_code = strap_div8 ? SEL_W'(STRAP_CODE) : '0;
  assign mask      = (CNT_W'(1) << act_q) - CNT_W'(1);
  assign clk_en    = (cnt_q == mask);
  assign rd_data   = {unlock_q, {(7-SEL_W){1'b0}}, sel_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      win_q    <= '0;
    end else if (unlock_q) begin
      if (take || win_q == '0) unlock_q <= 1'b0;
      else                     win_q    <= win_q - 1'b1;
    end else if (open_req) begin
      unlock_q <= 1'b1;
      win_q    <= WIN_W'(WIN_LEN - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= boot_code;
      pend_q <= boot_code;
    end else if (take) begin
      sel_q <= wr_data[SEL_W-1:0];
      if (code_ok) pend_q <= wr_data[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= boot_code;
      cnt_q <= '0;
    end else if (clk_en) begin
      act_q <= pend_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wr_data[7] && !unlock_q) |=> ($stable(sel_q) && $stable(pend_q)));

  assert_store_closes_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wr_data[7] && unlock_q) |=> (!unlock_q && sel_q == $past(wr_data[SEL_W-1:0])));

  assert_mixed_write_rejected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_data[7] && wr_data[SEL_W-1:0] != '0) |=> ($stable(sel_q) && $stable(unlock_q)));

  assert_factor_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_q <= SEL_W'(MAX_CODE));

  assert_switch_on_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(act_q));
endmodule

// File: tb/clk_prescale_guard_tb.sv
`timescale 1ns/1ps
module clk_prescale_guard_tb;
  logic clk = 0, rst_n = 0, strap = 0, wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic clk_en;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_prescale_guard u_dut (.clk(clk), .rst_n(rst_n), .strap_div8(strap),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_data(rd_data), .clk_en(clk_en));

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d, logic sel = 1'b1);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_sel = 0; wr_data = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic seek();
    while (!clk_en) @(negedge clk);
  endtask

  task automatic period(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!clk_en);
  endtask

  task automatic expect_period(string req, int exp);
    int n;
    seek(); period(n); check(req, n, exp);
    period(n); check(req, n, exp);
  endtask

  task automatic set_code(logic [3:0] c);
    wr(8'h80); wr({4'h0, c});
  endtask

  task automatic do_reset(logic s);
    rst_n = 0; strap = s;
    idle(3);
    check("R1 reset code", int'(rd_data), s ? 3 : 0);
    rst_n = 1;
  endtask

  initial begin
    int n;
    @(negedge clk);
    // R1: strap high gives divide by 8
    do_reset(1);
    n = 0;
    while (!clk_en) begin @(negedge clk); n++; end
    check("R1 first pulse", n, 7);
    expect_period("R1 strap period", 8);
    // R1: strap low gives divide by 1
    do_reset(0);
    check("R1 enable at div1", int'(clk_en), 1);
    check("R1 readback", int'(rd_data), 0);
    // R7 R9: sweep every legal code up and down
    for (int c = 0; c <= 8; c++) begin
      set_code(4'(c));
      check("R4 stored", int'(rd_data), c);
      expect_period("R7 R9 period", 1 << c);
    end
    for (int c = 7; c >= 0; c--) begin
      set_code(4'(c));
      expect_period("R7 R9 period down", 1 << c);
    end
    set_code(4'd2);
    expect_period("R7 div4", 4);
    // R8: reserved codes stored, factor kept
    for (int c = 9; c <= 15; c++) begin
      set_code(4'(c));
      check("R8 readback", int'(rd_data), c);
      expect_period("R8 factor held", 4);
    end
    set_code(4'd2);
    // R2: window length
    wr(8'h80);
    check("R2 open", int'(rd_data[7]), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); check("R2 still open", int'(rd_data[7]), 1);
    end
    @(negedge clk); check("R2 expired", int'(rd_data[7]), 0);
    // R3: locked write ignored
    wr(8'h05);
    check("R3 code kept", int'(rd_data), 2);
    expect_period("R3 factor kept", 4);
    // R4: last edge inside the window accepted
    wr(8'h80); idle(3); wr(8'h01);
    check("R4 last edge accepted", int'(rd_data), 1);
    // R4: one edge later rejected
    wr(8'h80); idle(4); wr(8'h03);
    check("R4 after window rejected", int'(rd_data), 1);
    // R5: rewrite does not extend
    wr(8'h80); idle(1); wr(8'h80);
    check("R5 not cleared", int'(rd_data[7]), 1);
    @(negedge clk); check("R5 open", int'(rd_data[7]), 1);
    @(negedge clk); check("R5 not extended", int'(rd_data[7]), 0);
    // R6: mixed write rejected
    wr(8'h85);
    check("R6 no open", int'(rd_data), 1);
    wr(8'h80); wr(8'h86);
    check("R6 rejected in window", int'(rd_data), 8'h81);
    idle(3);
    check("R6 window unaffected", int'(rd_data[7]), 0);
    // R10: write without select ignored
    wr(8'h80, 1'b0);
    check("R10 no open", int'(rd_data), 1);
    wr(8'h80); wr(8'h06, 1'b0);
    check("R10 code kept", int'(rd_data), 8'h81);
    wr(8'h04);
    check("R10 window still usable", int'(rd_data), 4);
    expect_period("R10 factor", 16);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule